// File: doc/BRIEF.md
# Triggered Buffer Activation Timer

This block turns a trigger pin into a buffer-enable control. A low-to-high transition on the trigger, after it has passed through a two-stage synchronizer and an edge detector, switches the internal buffer-active signal on. The signal stays on for as long as the trigger stays high. Once the trigger goes low, the signal stays on for a further stretch: a fixed minimum plus a programmable number of eight-cycle units.

A second output copies the buffer-active state onto an indicator pin. Its sense is chosen by a polarity input, so a board can use either an active-high or an active-low indicator. The analog buffer and the register file are outside the block. Only the hold-time field and the polarity bit enter as inputs.

Top module: `bufa_trigger_timer`

## Requirements
- R1: While reset is asserted and on the first edge after it, `act_o` is 0 and `ind_o` shows the inactive level for the current `pol_i`: 0 when `pol_i`=1 and 1 when `pol_i`=0.
- R2: A trigger that is already high during reset does not activate the buffer. Only a later low followed by a high starts it.
- R3: If the trigger is first sampled high at clock edge k, after being sampled low at the edge before, `act_o` becomes 1 after edge k+2. That is three clock edges after the input changes.
- R4: While the trigger stays high, `act_o` stays 1 with no time limit.
- R5: Let h be the last edge at which the trigger is sampled high. `act_o` stays 1 through edge h+E+2 and is 0 after edge h+E+3, where E = MIN_EXT + `hold_i` × UNIT. With the defaults, E = 3 + 8 × `hold_i`.
- R6: With `hold_i` = 0 the extension is the fixed minimum of 3 cycles.
- R7: A new rising edge during the extension restarts the hold. `act_o` does not drop between the two activations.
- R8: `ind_o` equals `act_o` when `pol_i` = 1 and equals its inverse when `pol_i` = 0. The output follows `pol_i` immediately.
- R9: A trigger pulse that is high for a single sample still activates the buffer, for 1 + E cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Asynchronous trigger pin |
| hold_i | input | HOLD_W | Programmable hold time, in units of UNIT cycles |
| pol_i | input | 1 | Indicator polarity: 1 means the indicator is high while active |
| act_o | output | 1 | Internal buffer-active signal |
| ind_o | output | 1 | Polarity-adjusted indicator output |

## Verification
The bench builds the block with its defaults: a 4-bit hold field, 8-cycle units, a minimum extension of 3 and two synchronizer stages. With these values the extension can be set anywhere from 3 to 123 cycles. The run uses hold values 0, 1, 2 and 15, so it covers the bare minimum, short and medium stretches, and the top of the counter range. Retriggers inside a running extension and single-sample pulses exercise the reload path, and polarity flips exercise the indicator sense.

// File: rtl/bufa_pkg.sv
package bufa_pkg;

    // Timer phases: off, trigger held, post-release stretch
    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_HELD   = 2'd1,
        BS_EXTEND = 2'd2
    } bufa_state_e;

    // Synchronized trigger information handed to the timer
    typedef struct packed {
        logic level;
        logic rise;
    } trig_evt_t;

    function automatic int unsigned ext_cycles(input int unsigned hold,
                                               input int unsigned min_ext,
                                               input int unsigned unit);
        return min_ext + hold * unit;
    endfunction

    function automatic logic ind_level(input logic act, input logic pol);
        return pol ? act : ~act;
    endfunction

endpackage

// File: rtl/bufa_trig_sync.sv
module bufa_trig_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_i,
    output bufa_pkg::trig_evt_t  evt_o
);
    logic [STAGES-1:0] sh;
    logic              prev;

    // Reset to "high" so a pin already high at reset yields no edge (R2)
    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], trig_i};
            prev <= sh[STAGES-1];
        end
    end

    assign evt_o.level = sh[STAGES-1];
    assign evt_o.rise  = sh[STAGES-1] & ~prev;

    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        evt_o.rise |=> !evt_o.rise);

endmodule

// File: rtl/bufa_hold_timer.sv
module bufa_hold_timer #(
    parameter int unsigned HOLD_W  = 4,
    parameter int unsigned UNIT    = 8,
    parameter int unsigned MIN_EXT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  bufa_pkg::trig_evt_t evt_i,
    input  logic [HOLD_W-1:0]   hold_i,
    output logic                act_o
);
    import bufa_pkg::*;

    localparam int unsigned EXT_MAX = MIN_EXT + ((2**HOLD_W) - 1) * UNIT;
    localparam int unsigned CNT_W   = $clog2(EXT_MAX + 1);

    bufa_state_e        st;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   ext_now;

    assign ext_now = CNT_W'(ext_cycles(32'(hold_i), MIN_EXT, UNIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                BS_IDLE: begin
                    if (evt_i.rise) begin
                        st  <= BS_HELD;
                        cnt <= ext_now;
                    end
                end
                BS_HELD: begin
                    if (evt_i.level) begin
                        cnt <= ext_now;
                    end else begin
                        st  <= BS_EXTEND;
                        cnt <= cnt - 1'b1;
                    end
                end
                BS_EXTEND: begin
                    if (evt_i.rise) begin
                        st  <= BS_HELD;
                        cnt <= ext_now;
                    end else if (cnt == '0) begin
                        st  <= BS_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st  <= BS_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign act_o = (st != BS_IDLE);

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        evt_i.rise |=> act_o);

    assert_held_R4: assert property (@(posedge clk) disable iff (rst)
        (act_o && evt_i.level) |=> act_o);

    assert_no_self_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!act_o && !evt_i.rise) |=> !act_o);

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (st == BS_EXTEND && evt_i.rise) |=> (st == BS_HELD));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(EXT_MAX));

endmodule

// File: rtl/bufa_ind_drive.sv
module bufa_ind_drive (
    input  logic act_i,
    input  logic pol_i,
    output logic ind_o
);
    assign ind_o = bufa_pkg::ind_level(act_i, pol_i);
endmodule

// File: rtl/bufa_trigger_timer.sv
module bufa_trigger_timer #(
    parameter int unsigned HOLD_W      = 4,
    parameter int unsigned UNIT        = 8,
    parameter int unsigned MIN_EXT     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] hold_i,
    input  logic              pol_i,
    output logic              act_o,
    output logic              ind_o
);
    bufa_pkg::trig_evt_t evt;

    bufa_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .evt_o  (evt)
    );

    bufa_hold_timer #(.HOLD_W(HOLD_W), .UNIT(UNIT), .MIN_EXT(MIN_EXT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .hold_i (hold_i),
        .act_o  (act_o)
    );

    bufa_ind_drive u_ind (
        .act_i (act_o),
        .pol_i (pol_i),
        .ind_o (ind_o)
    );

    assert_ind_change_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ind_o) |-> (!$stable(act_o) || !$stable(pol_i)));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> !act_o);

endmodule

// File: tb/sim_bufa_trigger_timer.sv
`timescale 1ns/1ps
module sim_bufa_trigger_timer;
    localparam int HW   = 4;
    localparam int UNIT = 8;
    localparam int MINX = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b1;
    logic          pol = 1'b1;
    logic [HW-1:0] hold = '0;
    logic          act, ind;

    int tests = 0;
    int fails = 0;
    int edge_n = 0;
    bit done = 0;

    typedef struct {
        int    due;
        bit    act;
        string tag;
    } exp_t;
    exp_t q[$];

    // requirement-level model state
    bit prev_s = 1'b1;
    bit on = 1'b0;
    int last_h = -100000;
    int ext_l = MINX;

    always #2 clk = ~clk;

    bufa_trigger_timer u0 (
        .clk(clk), .rst(rst), .trig_i(trig), .hold_i(hold),
        .pol_i(pol), .act_o(act), .ind_o(ind)
    );

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic check(bit got, bit want, string tag, string what);
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b (edge %0d)", tag, what, got, want, edge_n);
        end
    endtask

    // Driver: one trigger sample per clock, pushes the expected output
    task automatic run(bit v, int n, string tag);
        for (int i = 0; i < n; i++) begin
            int  k;
            bit  rise;
            bit  e;
            exp_t it;
            @(negedge clk);
            trig = v;
            k = edge_n;
            rise = v && !prev_s;
            prev_s = v;
            if (rise) on = 1'b1;
            if (v) begin
                last_h = k;
                ext_l = MINX + int'(hold) * UNIT;
            end
            e = on && ((k - last_h) <= ext_l);
            if (!e) on = 1'b0;
            it.due = k + 2;
            it.act = e;
            it.tag = tag;
            q.push_back(it);
        end
    endtask

    // Monitor: compares outputs once per edge, away from the edge
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= edge_n - 1) begin
            exp_t it;
            it = q.pop_front();
            if (it.due == edge_n - 1) begin
                check(act, it.act, it.tag, "act_o");
                check(ind, pol ? it.act : !it.act, (it.tag == "R8") ? "R8" : it.tag, "ind_o");
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, both polarities
        repeat (3) @(negedge clk);
        check(act, 1'b0, "R1", "act_o in reset");
        check(ind, 1'b0, "R1", "ind_o in reset pol=1");
        pol = 1'b0;
        #1;
        check(ind, 1'b1, "R1", "ind_o in reset pol=0");
        pol = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(act, 1'b0, "R1", "act_o first edge after reset");

        // R2: trigger high through reset must not start
        run(1'b1, 20, "R2");
        run(1'b0, 5, "R2");
        // R3 start latency, R6 minimum extension
        hold = '0;
        run(1'b1, 10, "R3");
        run(1'b0, 20, "R6");
        // R4 long hold, R5 programmed extension
        hold = 4'd2;
        run(1'b1, 60, "R4");
        run(1'b0, 40, "R5");
        // R9 single-sample pulse
        hold = '0;
        run(1'b1, 1, "R9");
        run(1'b0, 12, "R9");
        // R7 retrigger during extension
        hold = 4'd1;
        run(1'b1, 3, "R7");
        run(1'b0, 6, "R7");
        run(1'b1, 2, "R7");
        run(1'b0, 20, "R7");
        // R8 inverted polarity
        pol = 1'b0;
        run(1'b1, 4, "R8");
        run(1'b0, 20, "R8");
        pol = 1'b1;
        // R5 maximum hold field
        hold = 4'd15;
        run(1'b1, 2, "R5");
        run(1'b0, 135, "R5");
        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule